// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for a 12-bit serial converter that uses a chip-select, serial-clock and data-out interface. A start request lowers chip select with the serial clock held low, and the converter begins a conversion. The block then waits for the end of the conversion in one of two ways. It can wait a fixed maximum conversion time, or it can watch the data line for its rising edge. In the edge mode a timeout aborts the read if no edge arrives.

After the wait the block generates exactly thirteen serial clock cycles and samples the data line on every rising edge. The first sampled bit is the converter's high framing bit and is discarded. The other twelve bits form the result, MSB first. Chip select rises on the thirteenth falling edge, then stays high for a programmable minimum time before another read can start.

The data line passes through a two-flop synchronizer before it is sampled or edge-detected. The result leaves on a valid/ready output. `res_valid_o` rises with chip select and stays high, with `res_data_o` unchanged, until a cycle where `res_ready_i` is also high. While a result waits to be taken, no new read starts, so back-pressure stalls the converter and never drops a result. Start, mode, hold time, busy and error are plain level pins.

Top module: `adc_rd_ctrl`

## Requirements
- R1: A read starts by driving `adc_cs_n_o` low while `adc_sclk_o` is low. `adc_sclk_o` is low whenever `adc_cs_n_o` is high.
- R2: With `eoc_mode_i` = 0 (fixed wait), the first serial clock rising edge comes exactly CONV_CYC + HALF clock cycles after chip select falls, whatever the data line does.
- R3: With `eoc_mode_i` = 1 (edge wait), clocking starts after a rising edge on the synchronized data line. It starts no earlier than that edge and without waiting out CONV_CYC.
- R4: In edge mode, if no rising edge is seen, chip select rises after exactly CONV_CYC low cycles. `err_o` is then set, no serial clock edge is produced and no result is delivered. `err_o` clears when the next read is accepted.
- R5: Every high and low phase of the serial clock lasts HALF clock cycles. HALF is the larger of SCLK_HALF and ceil(CLK_HZ / 4,200,000), which keeps the serial clock at or below 2.1 MHz.
- R6: A completed read makes exactly 13 serial clock cycles. Chip select rises on the clock edge that makes the 13th falling edge.
- R7: The data line is sampled on serial clock rising edges. The first sample (the framing bit) is dropped. Samples 2 to 13 become `res_data_o` bits 11 down to 0.
- R8: After chip select rises it stays high for at least `cs_hold_i` cycles. If a start is already waiting, it stays high for exactly `cs_hold_i` + 1 cycles.
- R9: `res_valid_o` rises with chip select. It stays high with `res_data_o` stable until `res_ready_i` is high, and falls in the cycle after that transfer.
- R10: `start_i` is ignored while a read is in progress, during the chip-select hold time, and while a result is undelivered.
- R11: `busy_o` is high exactly while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Read request, taken when the block is able |
| eoc_mode_i | input | 1 | 0: fixed conversion wait, 1: wait for data rising edge |
| cs_hold_i | input | HOLD_W | Minimum chip-select high time in clock cycles |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Converter serial clock |
| adc_dout_i | input | 1 | Converter serial data (asynchronous) |
| busy_o | output | 1 | Read in progress |
| err_o | output | 1 | Last read aborted on end-of-conversion timeout |
| res_data_o | output | DATA_W | Conversion result |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Consumer accepts result |

## Verification
The bound checker watches, on every cycle, the properties that hold all the time. These are: serial clock idle while deselected, phase widths, the 13-rise count per completed frame, the chip-select high time, the stall of `res_valid_o`/`res_data_o` under back-pressure, no new read while a result is pending, busy tracking chip select, and the fixed-mode wait. Some behaviour needs a modelled converter, so only the bench scenarios can show it: that the assembled word equals the converter's word with the framing bit removed, exact timing of the edge-mode start against the converter's actual conversion time, the timeout abort with a silent converter, and the clearing of the error flag by the next read.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;

  // Fastest serial clock the converter accepts.
  localparam int unsigned SCLK_CAP_HZ = 2_100_000;

  // Half-period in system clocks: the requested value, raised if needed
  // so the serial clock never exceeds the cap.
  function automatic int unsigned half_cycles(int unsigned clk_hz, int unsigned req);
    int unsigned floor_h;
    floor_h = (clk_hz + 2 * SCLK_CAP_HZ - 1) / (2 * SCLK_CAP_HZ);
    if (floor_h < 1) floor_h = 1;
    return (req > floor_h) ? req : floor_h;
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int unsigned HALF   = 30,
  parameter int unsigned CYCLES = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o,
  output logic last_o
);

  localparam int unsigned DIV_W = $clog2(HALF + 1);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] falls_q;
  logic             sclk_q;
  logic             tick;

  assign tick = run_i && (div_q == DIV_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      falls_q <= '0;
      sclk_q  <= 1'b0;
    end else if (!run_i) begin
      div_q   <= '0;
      falls_q <= '0;
      sclk_q  <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
      if (sclk_q) falls_q <= falls_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign last_o = fall_o && (falls_q == CNT_W'(CYCLES - 1));

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              shift_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_valid_o,
  input  logic              res_ready_i
);

  localparam int unsigned FRAME = DATA_W + 1;

  logic [FRAME-1:0]  shreg_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg_q <= '0;
    else if (shift_i) shreg_q <= {shreg_q[FRAME-2:0], bit_i};
  end

  // The top bit of the frame is the framing bit and is never copied.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (done_i) begin
      data_q  <= shreg_q[DATA_W-1:0];
      valid_q <= 1'b1;
    end else if (valid_q && res_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign res_data_o  = data_q;
  assign res_valid_o = valid_q;

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned SCLK_HALF = 30,
  parameter int unsigned CONV_CYC  = 1000,
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned HOLD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              eoc_mode_i,
  input  logic [HOLD_W-1:0] cs_hold_i,
  output logic              adc_cs_n_o,
  output logic              adc_sclk_o,
  input  logic              adc_dout_i,
  output logic              busy_o,
  output logic              err_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_valid_o,
  input  logic              res_ready_i
);

  localparam int unsigned HALF   = half_cycles(CLK_HZ, SCLK_HALF);
  localparam int unsigned FRAME  = DATA_W + 1;
  localparam int unsigned WAIT_W = $clog2(CONV_CYC + 1);

  rd_state_e         state_q;
  logic [WAIT_W-1:0] wait_q;
  logic [HOLD_W-1:0] hold_q;
  logic              cs_n_q;
  logic              err_q;
  logic              dout_s;
  logic              dout_d;
  logic              rise_seen;
  logic              wait_end;
  logic              accept;
  logic              sck_rise;
  logic              sck_fall;
  logic              sck_last;

  adc_rd_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (adc_dout_i),
    .q_o   (dout_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dout_d <= 1'b0;
    else        dout_d <= dout_s;
  end

  assign rise_seen = dout_s && !dout_d;
  assign wait_end  = (wait_q == WAIT_W'(CONV_CYC - 1));
  assign accept    = (state_q == ST_IDLE) && start_i && !res_valid_o
                     && (hold_q >= cs_hold_i);

  adc_rd_sclk_gen #(.HALF(HALF), .CYCLES(FRAME)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (state_q == ST_SHIFT),
    .sclk_o (adc_sclk_o),
    .rise_o (sck_rise),
    .fall_o (sck_fall),
    .last_o (sck_last)
  );

  adc_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_i       (dout_s),
    .shift_i     (sck_rise),
    .done_i      (sck_last),
    .res_data_o  (res_data_o),
    .res_valid_o (res_valid_o),
    .res_ready_i (res_ready_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      hold_q  <= '0;
      cs_n_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_WAIT;
            cs_n_q  <= 1'b0;
            wait_q  <= '0;
            err_q   <= 1'b0;
          end else if (hold_q != {HOLD_W{1'b1}}) begin
            hold_q <= hold_q + 1'b1;
          end
        end
        ST_WAIT: begin
          wait_q <= wait_q + 1'b1;
          if (eoc_mode_i) begin
            if (rise_seen) begin
              state_q <= ST_SHIFT;
            end else if (wait_end) begin
              state_q <= ST_IDLE;
              cs_n_q  <= 1'b1;
              err_q   <= 1'b1;
              hold_q  <= '0;
            end
          end else if (wait_end) begin
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sck_last) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            hold_q  <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_cs_n_o = cs_n_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign err_o      = err_q;

  logic unused_fall;
  assign unused_fall = sck_fall;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned SCLK_HALF = 30,
  parameter int unsigned CONV_CYC  = 1000,
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned HOLD_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              eoc_mode,
  input logic [HOLD_W-1:0] cs_hold,
  input logic              busy,
  input logic              err,
  input logic [DATA_W-1:0] res_data,
  input logic              res_valid,
  input logic              res_ready
);

  localparam int unsigned HALF = half_cycles(CLK_HZ, SCLK_HALF);

  logic        sclk_q;
  logic        cs_n_q;
  logic [31:0] ph_q;
  logic [31:0] low_q;
  logic [31:0] high_q;
  logic [7:0]  rises_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      ph_q    <= '0;
      low_q   <= '0;
      high_q  <= '0;
      rises_q <= '0;
    end else begin
      sclk_q <= sclk;
      cs_n_q <= cs_n;
      if (sclk != sclk_q) ph_q <= 32'd1;
      else if (ph_q != '1) ph_q <= ph_q + 1;
      low_q  <= cs_n ? '0 : low_q + 1;
      high_q <= !cs_n ? '0 : ((high_q != '1) ? high_q + 1 : high_q);
      if (cs_n) rises_q <= '0;
      else if (sclk && !sclk_q) rises_q <= rises_q + 1'b1;
    end
  end

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_fixed_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_mode && sclk && !sclk_q) |-> (low_q >= CONV_CYC));

  p_abort_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (cs_n && !res_valid && rises_q == 8'd0));

  p_phase_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_q) |-> (ph_q >= HALF));

  p_frame_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_n_q) |-> ((rises_q == 8'd13) || (rises_q == 8'd0 && err)));

  p_cs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_n_q) |-> (high_q >= 32'(cs_hold)));

  p_result_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_no_start_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cs_n) |=> cs_n);

  p_busy_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .CLK_HZ    (CLK_HZ),
  .SCLK_HALF (SCLK_HALF),
  .CONV_CYC  (CONV_CYC),
  .DATA_W    (DATA_W),
  .HOLD_W    (HOLD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (adc_cs_n_o),
  .sclk      (adc_sclk_o),
  .eoc_mode  (eoc_mode_i),
  .cs_hold   (cs_hold_i),
  .busy      (busy_o),
  .err       (err_o),
  .res_data  (res_data_o),
  .res_valid (res_valid_o),
  .res_ready (res_ready_i)
);

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rd_ctrl;

  localparam int CONV = 300;
  localparam int EXP_HALF = 30;   // ceil(125e6 / 4.2e6), requested 4 is raised

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        eoc_mode_i = 1'b0;
  logic [15:0] cs_hold_i = 16'd20;
  logic        adc_cs_n_o, adc_sclk_o;
  logic        adc_dout_i = 1'b0;
  logic        busy_o, err_o;
  logic [11:0] res_data_o;
  logic        res_valid_o;
  logic        res_ready_i = 1'b1;

  always #4 clk = ~clk;

  adc_rd_ctrl #(
    .CLK_HZ(125_000_000), .SCLK_HALF(4), .CONV_CYC(CONV), .DATA_W(12), .HOLD_W(16)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .eoc_mode_i(eoc_mode_i),
    .cs_hold_i(cs_hold_i), .adc_cs_n_o(adc_cs_n_o), .adc_sclk_o(adc_sclk_o),
    .adc_dout_i(adc_dout_i), .busy_o(busy_o), .err_o(err_o),
    .res_data_o(res_data_o), .res_valid_o(res_valid_o), .res_ready_i(res_ready_i)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Converter model
  logic [11:0] m_word = '0;
  int  m_conv = 50;
  bit  m_respond = 1'b1;
  int  m_cnt = 0;
  int  m_sent = 0;
  bit  m_eoc = 1'b0;
  logic m_sclk_prev = 1'b0;

  always @(negedge clk) begin
    if (adc_cs_n_o) begin
      adc_dout_i = 1'b0; m_cnt = 0; m_eoc = 1'b0; m_sent = 0;
    end else if (!m_eoc) begin
      if (m_respond && m_cnt >= m_conv) begin
        m_eoc = 1'b1; adc_dout_i = 1'b1;
      end else m_cnt++;
    end else if (m_sclk_prev && !adc_sclk_o) begin
      adc_dout_i = (m_sent < 12) ? m_word[11-m_sent] : 1'b0;
      m_sent++;
    end
    m_sclk_prev = adc_sclk_o;
  end

  // Port monitor
  int  cyc = 0;
  logic cs_prev = 1'b1, sclk_prev = 1'b0;
  int  t_fall = 0, first_rise = -1, nrise = 0, minph = 1000000, ph = 0;
  int  lowcnt = 0, high_run = 0, last_high_run = 0, falls = 0;
  int  sclk_at_fall = 0, sclk_idle_bad = 0, busy_bad = 0, sclk_at_rise_cs = 0;
  int  got_cnt = 0;
  logic [11:0] got_data = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_prev && !adc_cs_n_o) begin
        t_fall = cyc; last_high_run = high_run; sclk_at_fall = adc_sclk_o;
        nrise = 0; first_rise = -1; minph = 1000000; lowcnt = 0; falls++;
      end
      if (!cs_prev && adc_cs_n_o) sclk_at_rise_cs = adc_sclk_o;
      if (adc_cs_n_o) high_run++; else begin high_run = 0; lowcnt++; end
      if (adc_sclk_o != sclk_prev) begin
        if (ph < minph) minph = ph;
        ph = 1;
        if (adc_sclk_o) begin
          nrise++;
          if (first_rise < 0) first_rise = cyc;
        end
      end else ph++;
      if (adc_cs_n_o && adc_sclk_o) sclk_idle_bad++;
      if (busy_o != !adc_cs_n_o) busy_bad++;
      if (res_valid_o && res_ready_i) begin got_cnt++; got_data = res_data_o; end
    end
    cs_prev = adc_cs_n_o;
    sclk_prev = adc_sclk_o;
  end

  task automatic start_read();
    int n = 0;
    @(negedge clk);
    start_i = 1'b1;
    while (!busy_o && n < 5000) begin @(negedge clk); n++; end
    start_i = 1'b0;
  endtask

  task automatic finish_read();
    int n = 0;
    while (busy_o && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input bit mode, input logic [11:0] w, input int conv, input bit resp);
    eoc_mode_i = mode; m_word = w; m_conv = conv; m_respond = resp;
    start_read();
    finish_read();
  endtask

  task automatic t_reset();
    check("R1 reset cs_n", int'(adc_cs_n_o), 1);
    check("R1 reset sclk", int'(adc_sclk_o), 0);
    check("R11 reset busy", int'(busy_o), 0);
    check("R9 reset valid", int'(res_valid_o), 0);
    check("R4 reset err", int'(err_o), 0);
  endtask

  task automatic t_fixed();
    int g = got_cnt;
    do_read(1'b0, 12'hA5C, 50, 1'b1);
    check("R7 fixed data", int'(got_data), 12'hA5C);
    check("R9 one transfer", got_cnt - g, 1);
    check("R2 fixed first rise", first_rise - t_fall, CONV + EXP_HALF);
    check("R6 rises per frame", nrise, 13);
    check("R5 min phase", minph, EXP_HALF);
    check("R1 sclk low at cs fall", sclk_at_fall, 0);
    check("R6 sclk low at cs rise", sclk_at_rise_cs, 0);
  endtask

  task automatic t_edge(input logic [11:0] w, input int conv);
    int gap;
    do_read(1'b1, w, conv, 1'b1);
    gap = first_rise - t_fall;
    check("R7 edge data", int'(got_data), int'(w));
    check("R3 starts after edge", int'(gap > conv), 1);
    check("R3 no full wait", int'(gap < CONV), 1);
    check("R6 edge rises", nrise, 13);
  endtask

  task automatic t_timeout();
    int g = got_cnt;
    do_read(1'b1, 12'h123, 0, 1'b0);
    check("R4 low time", lowcnt, CONV);
    check("R4 err set", int'(err_o), 1);
    check("R4 no sclk", nrise, 0);
    check("R4 no result", got_cnt - g, 0);
    do_read(1'b1, 12'h456, 80, 1'b1);
    check("R4 err cleared", int'(err_o), 0);
    check("R4 next data", int'(got_data), 12'h456);
  endtask

  task automatic t_hold();
    cs_hold_i = 16'd150;
    eoc_mode_i = 1'b1; m_word = 12'h0F0; m_conv = 40; m_respond = 1'b1;
    start_read();
    start_i = 1'b1;   // keep the next request waiting
    while (!adc_cs_n_o) @(negedge clk);
    while (adc_cs_n_o) @(negedge clk);
    start_i = 1'b0;
    check("R8 cs high time", last_high_run, 151);
    finish_read();
    check("R7 hold data", int'(got_data), 12'h0F0);
    cs_hold_i = 16'd20;
  endtask

  task automatic t_backpressure();
    int f;
    logic [11:0] held;
    int stall_bad = 0;
    res_ready_i = 1'b0;
    do_read(1'b0, 12'hC3A, 30, 1'b1);
    held = res_data_o;
    check("R9 valid held", int'(res_valid_o), 1);
    check("R7 held data", int'(held), 12'hC3A);
    f = falls;
    start_i = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!res_valid_o || res_data_o != held || !adc_cs_n_o) stall_bad++;
    end
    check("R9 stall stable", stall_bad, 0);
    check("R10 no start while pending", falls - f, 0);
    res_ready_i = 1'b1;
    @(negedge clk);
    check("R9 valid drops", int'(res_valid_o), 0);
    while (!busy_o) @(negedge clk);
    start_i = 1'b0;
    finish_read();
    check("R10 start after drain", falls - f, 1);
  endtask

  task automatic t_ignore();
    int f = falls;
    eoc_mode_i = 1'b0; m_word = 12'h5A5; m_conv = 20; m_respond = 1'b1;
    start_read();
    repeat (400) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_read();
    repeat (30) @(negedge clk);
    check("R10 start ignored busy", falls - f, 1);
    check("R10 idle after", int'(adc_cs_n_o), 1);
    check("R7 ignore data", int'(got_data), 12'h5A5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (30) @(negedge clk);
    t_fixed();
    t_edge(12'h3F1, 100);
    t_edge(12'hFFF, 60);
    t_edge(12'h000, 150);
    t_timeout();
    t_hold();
    t_backpressure();
    t_ignore();
    check("R1 sclk idle while deselected", sclk_idle_bad, 0);
    check("R11 busy tracks cs", busy_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule